// File: doc/BRIEF.md
# Clock Divider Change Sequencer

This block changes the divider code of a display clock generator. It protects the downstream pixel FIFOs from the large rate jump that happens when the code moves onto or off the top code (all ones, 127 for a 7-bit code). A request carries a target code, and the block compares it with the code it last programmed.

A move off the top code first trims every eligible pipe's FIFO by issuing drop-pixel pulses, and then writes the target. A move onto the top code first steps the divider to 126 and waits for the clock generator's change-done flag. It then pads every eligible pipe with add-pixel pulses and writes the top code last. Any other change is written at once.

The number of pulses for a pipe comes from its FIFO average level divided by four. Pipes are handled one at a time, in ascending index order. Each pipe's pulses are framed by an error-detect override output, so the FIFO checker ignores the deliberate disturbance.

Top module: `dclk_div_sequencer`

## Requirements
- R1: After reset, busy_o, done_o, errdet_ovr_o, div_wr_o, timeout_o and all pixel pulses are low, and div_code_o shows the reset code (64 by default).
- R2: If the change neither enters nor leaves the top code, the target is written with div_wr_o high and div_code_o equal to the target in the cycle after acceptance, and no pixel pulses are issued. This includes a top-to-top request.
- R3: When the current code is the top code and the target differs, each eligible pipe receives max(L/4 - 4, 0) drop pulses on drop_px_o[i], where L is the 8-bit level at fifo_lvl_i[i*8 +: 8] and the division is integer. The single write of the target comes after the last drop pulse.
- R4: When the target is the top code and the current code is not, the block first writes 126. It then waits for chg_done_i, which it samples once every POLL_INTERVAL cycles. Only after that does each eligible pipe receive max(12 - L/4, 0) add pulses on add_px_o[i], and the top code is written last.
- R5: A pipe whose pipe_active_i bit or lvl_valid_i bit is low receives no pulses.
- R6: Pipes are served in ascending index order, one at a time, with at most one pulse per cycle. Pulses occur only while errdet_ovr_o is high, and errdet_ovr_o goes low for at least one cycle between two pipes.
- R7: errdet_ovr_o is high for exactly one cycle without a pulse for each pipe that receives pulses. A pipe with a count of zero causes no override at all.
- R8: If chg_done_i is not seen in POLL_LIMIT polls, timeout_o goes high and the sequence continues to its end. timeout_o stays high until the next request is accepted, which clears it.
- R9: busy_o is high from the cycle after acceptance until done_o has been shown. A request made while busy_o is high is ignored.
- R10: done_o is high for exactly one cycle, the cycle right after the final divider write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Change request, taken when idle |
| target_i | input | CODE_W | Requested divider code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Change-done wait expired (held until next request) |
| div_wr_o | output | 1 | Divider write strobe |
| div_code_o | output | CODE_W | Code being written, else the current code |
| chg_done_i | input | 1 | Clock generator reports change finished |
| fifo_lvl_i | input | NUM_PIPES*LVL_W | Per-pipe FIFO average levels |
| pipe_active_i | input | NUM_PIPES | Pipe carries a stream |
| lvl_valid_i | input | NUM_PIPES | Pipe level is available |
| errdet_ovr_o | output | 1 | FIFO error-detect override |
| drop_px_o | output | NUM_PIPES | Drop-pixel pulses |
| add_px_o | output | NUM_PIPES | Add-pixel pulses |

## Verification
On a plain change, the divider write is due in the first cycle after the accepting edge, and done follows one cycle later. The bench samples both exactly there, half a cycle after each edge. Compensated changes take a length that depends on the levels and on when change-done arrives. For these, a negedge monitor records the cycle of every write, every pulse and the rise of change-done, and the checks compare the order of these events rather than absolute cycle numbers. Done is always checked against the cycle that follows the last recorded write, and the idle state is checked one cycle after done.

// File: rtl/dclk_seq_pkg.sv
package dclk_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_STEP_WR,
    S_POLL,
    S_PICK,
    S_OVR_ON,
    S_PULSE,
    S_OVR_OFF,
    S_FINAL_WR,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_NONE,
    MODE_DROP,
    MODE_ADD
  } comp_mode_e;

  localparam int DROP_BIAS  = 4;
  localparam int ADD_TARGET = 12;

endpackage

// File: rtl/dclk_pipe_pick.sv
module dclk_pipe_pick #(
  parameter int NUM_PIPES = 4,
  localparam int IDX_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
  localparam int PW    = IDX_W + 1
) (
  input  logic [NUM_PIPES-1:0] elig_i,
  input  logic [PW-1:0]        start_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);

  logic [NUM_PIPES-1:0] masked;

  genvar g;
  generate
    for (g = 0; g < NUM_PIPES; g++) begin : g_mask
      assign masked[g] = elig_i[g] && (PW'(g) >= start_i);
    end
  endgenerate

  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_PIPES - 1; i >= 0; i--) begin
      if (masked[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dclk_comp_calc.sv
module dclk_comp_calc import dclk_seq_pkg::*; #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic             add_mode_i,
  output logic [LVL_W-1:0] cnt_o
);

  logic [LVL_W-1:0] quarter;
  logic [LVL_W-1:0] drop_cnt;
  logic [LVL_W-1:0] add_cnt;

  always_comb begin
    quarter  = level_i >> 2;
    drop_cnt = (quarter > LVL_W'(DROP_BIAS)) ? (quarter - LVL_W'(DROP_BIAS)) : '0;
    add_cnt  = (quarter < LVL_W'(ADD_TARGET)) ? (LVL_W'(ADD_TARGET) - quarter) : '0;
    cnt_o    = add_mode_i ? add_cnt : drop_cnt;
  end

endmodule

// File: rtl/dclk_poll_timer.sv
module dclk_poll_timer #(
  parameter int INTERVAL = 100,
  parameter int LIMIT    = 50,
  localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1,
  localparam int LW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic chg_done_i,
  output logic seen_o,
  output logic expire_o
);

  logic [IW-1:0] int_q, int_d;
  logic [LW-1:0] poll_q, poll_d;
  logic          tick;

  assign tick     = run_i && (int_q == IW'(INTERVAL - 1));
  assign seen_o   = tick && chg_done_i;
  assign expire_o = tick && !chg_done_i && (poll_q == LW'(LIMIT - 1));

  always_comb begin
    int_d  = int_q;
    poll_d = poll_q;
    if (clear_i) begin
      int_d  = '0;
      poll_d = '0;
    end else if (run_i) begin
      if (tick) begin
        int_d  = '0;
        poll_d = poll_q + LW'(1);
      end else begin
        int_d = int_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= '0;
      poll_q <= '0;
    end else begin
      int_q  <= int_d;
      poll_q <= poll_d;
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (poll_q < LW'(LIMIT))); // R8

endmodule

// File: rtl/dclk_div_sequencer.sv
module dclk_div_sequencer import dclk_seq_pkg::*; #(
  parameter int NUM_PIPES     = 4,
  parameter int LVL_W         = 8,
  parameter int CODE_W        = 7,
  parameter int POLL_INTERVAL = 100,
  parameter int POLL_LIMIT    = 50,
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(64)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [CODE_W-1:0]          target_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       timeout_o,
  output logic                       div_wr_o,
  output logic [CODE_W-1:0]          div_code_o,
  input  logic                       chg_done_i,
  input  logic [NUM_PIPES*LVL_W-1:0] fifo_lvl_i,
  input  logic [NUM_PIPES-1:0]       pipe_active_i,
  input  logic [NUM_PIPES-1:0]       lvl_valid_i,
  output logic                       errdet_ovr_o,
  output logic [NUM_PIPES-1:0]       drop_px_o,
  output logic [NUM_PIPES-1:0]       add_px_o
);

  localparam int IDX_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;
  localparam int PW    = IDX_W + 1;
  localparam logic [CODE_W-1:0] TOP_CODE  = '1;
  localparam logic [CODE_W-1:0] STEP_CODE = TOP_CODE - CODE_W'(1);

  seq_state_e        state_q, state_d;
  comp_mode_e        mode_q, mode_d;
  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] cur_q, cur_d;
  logic [PW-1:0]     start_q, start_d;
  logic [IDX_W-1:0]  pipe_q, pipe_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;
  logic              tmo_q, tmo_d;
  logic              accept;

  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic [LVL_W-1:0]  lvl_arr [NUM_PIPES];
  logic [LVL_W-1:0]  lvl_sel;
  logic [LVL_W-1:0]  calc_cnt;
  logic              poll_seen;
  logic              poll_expire;
  logic              pulse_now;

  genvar g;
  generate
    for (g = 0; g < NUM_PIPES; g++) begin : g_lvl
      assign lvl_arr[g] = fifo_lvl_i[g*LVL_W +: LVL_W];
    end
  endgenerate

  assign lvl_sel = lvl_arr[pick_idx];
  assign accept  = (state_q == S_IDLE) && req_i;

  dclk_pipe_pick #(
    .NUM_PIPES (NUM_PIPES)
  ) u_pick (
    .elig_i  (pipe_active_i & lvl_valid_i),
    .start_i (start_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  dclk_comp_calc #(
    .LVL_W (LVL_W)
  ) u_calc (
    .level_i    (lvl_sel),
    .add_mode_i (mode_q == MODE_ADD),
    .cnt_o      (calc_cnt)
  );

  dclk_poll_timer #(
    .INTERVAL (POLL_INTERVAL),
    .LIMIT    (POLL_LIMIT)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (state_q == S_STEP_WR),
    .run_i      (state_q == S_POLL),
    .chg_done_i (chg_done_i),
    .seen_o     (poll_seen),
    .expire_o   (poll_expire)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cur_d   = cur_q;
    start_d = start_q;
    pipe_d  = pipe_q;
    cnt_d   = cnt_q;
    tmo_d   = tmo_q;
    unique case (state_q)
      S_IDLE: begin
        if (req_i) begin
          tmo_d   = 1'b0;
          start_d = '0;
          if (cur_q == TOP_CODE && target_i != TOP_CODE) begin
            mode_d  = MODE_DROP;
            state_d = S_PICK;
          end else if (target_i == TOP_CODE && cur_q != TOP_CODE) begin
            mode_d  = MODE_ADD;
            state_d = S_STEP_WR;
          end else begin
            mode_d  = MODE_NONE;
            state_d = S_FINAL_WR;
          end
        end
      end
      S_STEP_WR: begin
        cur_d   = STEP_CODE;
        state_d = S_POLL;
      end
      S_POLL: begin
        if (poll_seen) begin
          state_d = S_PICK;
        end else if (poll_expire) begin
          tmo_d   = 1'b1;
          state_d = S_PICK;
        end
      end
      S_PICK: begin
        if (!pick_found) begin
          state_d = S_FINAL_WR;
        end else if (calc_cnt == '0) begin
          start_d = PW'(pick_idx) + PW'(1);
        end else begin
          pipe_d  = pick_idx;
          cnt_d   = calc_cnt;
          state_d = S_OVR_ON;
        end
      end
      S_OVR_ON: state_d = S_PULSE;
      S_PULSE: begin
        cnt_d = cnt_q - LVL_W'(1);
        if (cnt_q == LVL_W'(1)) state_d = S_OVR_OFF;
      end
      S_OVR_OFF: begin
        start_d = PW'(pipe_q) + PW'(1);
        state_d = S_PICK;
      end
      S_FINAL_WR: begin
        cur_d   = tgt_q;
        state_d = S_DONE;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= MODE_NONE;
      cur_q   <= RESET_CODE;
      start_q <= '0;
      pipe_q  <= '0;
      cnt_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cur_q   <= cur_d;
      start_q <= start_d;
      pipe_q  <= pipe_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= RESET_CODE;
    end else if (accept) begin
      tgt_q <= target_i;
    end
  end

  // output decode
  assign pulse_now    = (state_q == S_PULSE);
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign timeout_o    = tmo_q;
  assign errdet_ovr_o = (state_q == S_OVR_ON) || pulse_now;
  assign div_wr_o     = (state_q == S_STEP_WR) || (state_q == S_FINAL_WR);

  always_comb begin
    div_code_o = cur_q;
    if (state_q == S_STEP_WR)  div_code_o = STEP_CODE;
    if (state_q == S_FINAL_WR) div_code_o = tgt_q;
  end

  generate
    for (g = 0; g < NUM_PIPES; g++) begin : g_px
      assign drop_px_o[g] = pulse_now && (mode_q == MODE_DROP) && (pipe_q == IDX_W'(g));
      assign add_px_o[g]  = pulse_now && (mode_q == MODE_ADD)  && (pipe_q == IDX_W'(g));
    end
  endgenerate

  // assertions
  AST_PULSE_IN_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|drop_px_o) || (|add_px_o)) |-> errdet_ovr_o); // R6

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drop_px_o, add_px_o})); // R6

  AST_DROP_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop_px_o) |-> (cur_q == TOP_CODE)); // R3

  AST_ADD_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|add_px_o) |-> (cur_q == STEP_CODE)); // R4

  AST_TOP_VIA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr_o && div_code_o == TOP_CODE) |-> (cur_q == STEP_CODE || cur_q == TOP_CODE)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!errdet_ovr_o && !div_wr_o && drop_px_o == '0 && add_px_o == '0)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(div_wr_o)); // R10

endmodule

// File: tb/dclk_div_sequencer_test.sv
module dclk_div_sequencer_test;

  localparam int NP = 4;
  localparam int LW = 8;
  localparam logic [6:0] RST_CODE = 7'd64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0;
  logic [6:0]      tgt = '0;
  logic            chg_done = 1'b0;
  logic [NP*LW-1:0] lvls = '0;
  logic [NP-1:0]   act = '0;
  logic [NP-1:0]   vld = '0;
  logic            busy, done, tmo, wr, ovr;
  logic [6:0]      code;
  logic [NP-1:0]   drop, add;

  dclk_div_sequencer uut (
    .clk (clk), .rst_n (rst_n), .req_i (req), .target_i (tgt),
    .busy_o (busy), .done_o (done), .timeout_o (tmo),
    .div_wr_o (wr), .div_code_o (code), .chg_done_i (chg_done),
    .fifo_lvl_i (lvls), .pipe_active_i (act), .lvl_valid_i (vld),
    .errdet_ovr_o (ovr), .drop_px_o (drop), .add_px_o (add)
  );

  always #10 clk = ~clk;

  int pass_n = 0;
  int fail_n = 0;
  int cyc = 0;
  logic [6:0] bench_cur = RST_CODE;

  // monitor state
  int drop_cnt [NP];
  int add_cnt [NP];
  int order_viol, gap_viol, multi_viol, ovr_viol, ovr_nopulse;
  int last_pipe;
  bit gap_seen;
  int wr_n;
  logic [6:0] wr_code [4];
  int wr_last_cyc, first_pulse_cyc, last_pulse_cyc;
  int chg_cnt, chg_delay, chg_rise_cyc;

  always @(negedge clk) begin
    cyc++;
    if ($countones({drop, add}) > 1) multi_viol++;
    if ((|drop) || (|add)) begin
      int p;
      p = 0;
      for (int i = 0; i < NP; i++) if (drop[i] || add[i]) p = i;
      if (drop[p]) drop_cnt[p]++;
      if (add[p]) add_cnt[p]++;
      if (!ovr) ovr_viol++;
      if (last_pipe >= 0 && p != last_pipe && !gap_seen) gap_viol++;
      if (p < last_pipe) order_viol++;
      last_pipe = p;
      gap_seen = 1'b0;
      if (first_pulse_cyc < 0) first_pulse_cyc = cyc;
      last_pulse_cyc = cyc;
    end else if (ovr) begin
      ovr_nopulse++;
    end
    if (!ovr) gap_seen = 1'b1;
    if (wr) begin
      if (wr_n < 4) wr_code[wr_n] = code;
      wr_n++;
      wr_last_cyc = cyc;
      if (code == 7'd126) chg_cnt = chg_delay;
    end else if (chg_cnt > 0) begin
      chg_cnt--;
    end
    if (chg_cnt == 0 && !chg_done) begin
      chg_done = 1'b1;
      chg_rise_cyc = cyc;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 190000) begin
        fail_n++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string rq, int actual, int expected);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d", rq, actual, expected);
    end
  endtask

  function automatic int exp_pulses(int lvl, bit add_mode);
    int n;
    n = lvl / 4;
    if (add_mode) return (n < 12) ? 12 - n : 0;
    return (n > 4) ? n - 4 : 0;
  endfunction

  task automatic do_op(logic [6:0] t, int dly, bit poke);
    int mode; // 0 plain, 1 drop, 2 add
    int g;
    int ed, ea, nz;
    bit elig;
    if (bench_cur == 7'd127 && t != 7'd127) mode = 1;
    else if (t == 7'd127 && bench_cur != 7'd127) mode = 2;
    else mode = 0;
    for (int i = 0; i < NP; i++) begin
      drop_cnt[i] = 0;
      add_cnt[i] = 0;
    end
    order_viol = 0; gap_viol = 0; multi_viol = 0; ovr_viol = 0; ovr_nopulse = 0;
    last_pipe = -1; gap_seen = 1'b1; wr_n = 0; wr_last_cyc = -1;
    first_pulse_cyc = -1; last_pulse_cyc = -1;
    chg_delay = dly; chg_cnt = -1; chg_done = 1'b0; chg_rise_cyc = -1;
    req = 1'b1; tgt = t;
    step();
    req = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (mode == 0) chk(wr && code == t, "R2 immediate write", code, t);
    if (poke) begin
      req = 1'b1; tgt = t ^ 7'h15;
      step();
      req = 1'b0;
    end
    g = 0;
    while (!done && g < 20000) begin
      step();
      g++;
    end
    chk(done == 1'b1, "R10 done reached", done, 1);
    chk(wr_last_cyc == cyc - 1, "R10 done follows final write", wr_last_cyc, cyc - 1);
    nz = 0;
    for (int i = 0; i < NP; i++) begin
      elig = act[i] && vld[i];
      ed = (elig && mode == 1) ? exp_pulses(int'(lvls[i*LW +: LW]), 1'b0) : 0;
      ea = (elig && mode == 2) ? exp_pulses(int'(lvls[i*LW +: LW]), 1'b1) : 0;
      if (ed + ea > 0) nz++;
      if (!elig) chk(drop_cnt[i] == 0 && add_cnt[i] == 0, "R5 skipped pipe",
                     drop_cnt[i] + add_cnt[i], 0);
      else if (mode == 1) chk(drop_cnt[i] == ed && add_cnt[i] == 0, "R3 drop count",
                              drop_cnt[i], ed);
      else if (mode == 2) chk(add_cnt[i] == ea && drop_cnt[i] == 0, "R4 add count",
                              add_cnt[i], ea);
      else chk(drop_cnt[i] == 0 && add_cnt[i] == 0, "R2 no pulses",
               drop_cnt[i] + add_cnt[i], 0);
    end
    chk(order_viol + gap_viol + multi_viol + ovr_viol == 0, "R6 order/override",
        order_viol + gap_viol + multi_viol + ovr_viol, 0);
    chk(ovr_nopulse == nz, "R7 override per pulsed pipe", ovr_nopulse, nz);
    if (mode == 2) begin
      chk(wr_n == 2 && wr_code[0] == 7'd126 && wr_code[1] == 7'd127,
          "R4 write sequence", wr_n, 2);
      if (first_pulse_cyc >= 0 && dly >= 0)
        chk(first_pulse_cyc > chg_rise_cyc, "R4 pulses after change-done",
            first_pulse_cyc, chg_rise_cyc + 1);
      chk(tmo == (dly < 0), "R8 timeout flag", tmo, (dly < 0));
    end else begin
      chk(wr_n == 1 && wr_code[0] == t, "R3 single target write", wr_n, 1);
      if (mode == 1 && last_pulse_cyc >= 0)
        chk(last_pulse_cyc < wr_last_cyc, "R3 write after pulses", last_pulse_cyc, wr_last_cyc);
      chk(tmo == 1'b0, "R8 timeout cleared", tmo, 0);
    end
    step();
    chk(!done && !busy, "R10 done single cycle", done, 0);
    chk(code == t && !wr, "R9 code holds target", code, t);
    bench_cur = t;
  endtask

  initial begin
    int r;
    logic [6:0] t;
    void'($urandom(32'h5EED_1234));
    step();
    step();
    chk(!busy && !done && !ovr && !wr && !tmo && drop == '0 && add == '0,
        "R1 reset outputs", {busy, done, ovr, wr, tmo}, 0);
    chk(code == RST_CODE, "R1 reset code", code, RST_CODE);
    rst_n = 1'b1;
    step();

    // plain change
    lvls = {8'd200, 8'd10, 8'd90, 8'd30}; act = '1; vld = '1;
    do_op(7'd10, 0, 1'b0);
    // enter top: pipe levels 0, 47(invalid), 48, 30
    lvls = {8'd30, 8'd48, 8'd47, 8'd0}; act = 4'b1111; vld = 4'b1101;
    do_op(7'd127, 30, 1'b0);
    // top to top is plain
    do_op(7'd127, 0, 1'b0);
    // leave top with boundaries and a request while busy
    lvls = {8'd100, 8'd20, 8'd19, 8'd255}; act = 4'b1011; vld = '1;
    do_op(7'd5, 0, 1'b1);
    // enter top without change-done
    lvls = {8'd4, 8'd44, 8'd12, 8'd40}; act = '1; vld = '1;
    do_op(7'd127, -1, 1'b0);
    // leave again, timeout must be cleared
    lvls = {8'd60, 8'd23, 8'd16, 8'd21};
    do_op(7'd126, 0, 1'b0);

    for (int k = 0; k < 24; k++) begin
      r = $urandom % 4;
      if (r == 0) t = 7'd127;
      else if (r == 1) t = 7'd126;
      else t = 7'($urandom % 128);
      for (int i = 0; i < NP; i++) lvls[i*LW +: LW] = 8'($urandom % 256);
      act = 4'($urandom);
      vld = 4'($urandom);
      do_op(t, int'($urandom % 300), (k % 3) == 0);
    end

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

endmodule